// File: doc/BRIEF.md
# Accumulator Control Processor Core

This block is a small 8-bit processor for sequencing peripheral hardware. It has no adder. Its work is moving bytes between one accumulator and a bank of sixteen registers, testing and changing single accumulator bits, counting in binary or packed BCD, and skipping instructions on comparison results. It reads single-byte instructions from an external program store over an 11-bit address bus. It drives a 7-bit direct-control output bus, which firmware uses to raise and drop handshake lines.

Each instruction takes exactly two clocks. In the first clock the program counter is on the address bus and the instruction byte is captured. In the second clock the instruction executes. Jumps and calls take their 11-bit target from three low opcode bits, which give the high part, and the accumulator, which gives the low byte. Every instruction therefore fits in one byte and keeps the two-clock rhythm. A single external interrupt line forces a jump to a fixed vector. A one-level return register serves both calls and interrupts.

Top module: `ctl_core`

## Requirements
- R1: While rst_ni is low and after it is released, the address bus, accumulator output and direct-control bus are all zero, and interrupts are disabled.
- R2: The address bus holds the program counter and changes only at the end of the second (execute) clock of each instruction. Without a skip or a transfer of control, the counter advances by one, modulo 2048.
- R3: Opcode 0x00+r loads register r into the accumulator. Opcode 0x10+r stores the accumulator into register r. Opcode 0x60+n loads the 4-bit value n, zero-extended.
- R4: Opcode 0x50+b sets accumulator bit b to one. Opcode 0x58+b clears it (b in 0..7).
- R5: Opcode 0x40+b skips the next instruction when accumulator bit b is one. Opcode 0x48+b skips it when the bit is zero. A skip advances the counter by two.
- R6: Opcode 0x20+r skips when the accumulator equals register r. Opcode 0x30+r skips when the accumulator is greater than register r, compared unsigned.
- R7: Opcode 0x80 increments and 0x81 decrements the accumulator in binary, modulo 256. Opcode 0x84 complements it and 0x85 clears it.
- R8: Opcode 0x82 increments and 0x83 decrements the accumulator as two packed BCD digits. 0x99 increments to 0x00 and 0x00 decrements to 0x99.
- R9: Opcode 0x70+k sets direct-control bit k and 0x78+k clears it (k in 0..6). Opcode 0x77 copies accumulator bits 6..0 onto the bus. The bus changes at no other time.
- R10: Opcode 0xC0+h jumps to {h, accumulator}. Opcode 0xC8+h does the same and saves the following address in the return register. Opcode 0x86 returns to the saved address.
- R11: When irq_i is high at the end of an execute clock and interrupts are enabled, the next address is saved, control moves to IRQ_VEC and interrupts are disabled. Opcode 0x87 returns and re-enables. 0x88 enables and 0x89 disables. irq_i has no effect while interrupts are disabled.
- R12: All other opcodes change nothing except advancing the counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | External interrupt request, level sensitive |
| instr_i | input | 8 | Instruction byte from program store |
| addr_o | output | ADDR_W | Program address (program counter) |
| acc_o | output | 8 | Accumulator value |
| dctl_o | output | 7 | Direct-control output bus |

## Verification
A corrupted program counter, return register or skip decision shows on addr_o at the next execute edge, so it is visible within two clocks. A bad accumulator, register or BCD carry shows on acc_o in the same execute clock, or for a register, when that register is next loaded back into the accumulator. A wrong interrupt-enable state appears as a vector jump that is taken or missed at the first execute edge where irq_i is high. The bench runs a reference model in step with the core and compares all three outputs on every clock, so the first divergence is reported in the cycle where it occurs.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int DATA_W = 8;
  localparam int REG_N  = 16;
  localparam int REG_AW = $clog2(REG_N);
  localparam int DCTL_W = 7;

  localparam logic [7:0] OP_INB = 8'h80;
  localparam logic [7:0] OP_DEB = 8'h81;
  localparam logic [7:0] OP_INBCD = 8'h82;
  localparam logic [7:0] OP_DEBCD = 8'h83;
  localparam logic [7:0] OP_CPL = 8'h84;
  localparam logic [7:0] OP_CLA = 8'h85;
  localparam logic [7:0] OP_RET = 8'h86;
  localparam logic [7:0] OP_RTI = 8'h87;
  localparam logic [7:0] OP_EI  = 8'h88;
  localparam logic [7:0] OP_DI  = 8'h89;
  localparam logic [7:0] OP_DOUT = 8'h77;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] lo, hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo >= 4'd9) begin
      lo = 4'd0;
      hi = (hi >= 4'd9) ? 4'd0 : hi + 4'd1;
    end else begin
      lo = lo + 4'd1;
    end
    return {hi, lo};
  endfunction

  function automatic logic [7:0] bcd_dec(input logic [7:0] v);
    logic [3:0] lo, hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo == 4'd0) begin
      lo = 4'd9;
      hi = (hi == 4'd0) ? 4'd9 : hi - 4'd1;
    end else begin
      lo = lo - 4'd1;
    end
    return {hi, lo};
  endfunction
endpackage

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (we_i && idx_i == REG_AW'(g))          regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx_i];
endmodule

// File: rtl/ctl_acc_unit.sv
module ctl_acc_unit
  import ctl_pkg::*;
(
  input  logic [7:0]        ir_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] acc_nx_o,
  output logic              acc_we_o,
  output logic              skip_o
);
  always_comb begin
    acc_nx_o = acc_i;
    acc_we_o = 1'b0;
    skip_o   = 1'b0;
    case (ir_i[7:4])
      4'h0: begin acc_nx_o = reg_i; acc_we_o = 1'b1; end
      4'h2: skip_o = (acc_i == reg_i);
      4'h3: skip_o = (acc_i > reg_i);
      4'h4: skip_o = ir_i[3] ? !acc_i[ir_i[2:0]] : acc_i[ir_i[2:0]];
      4'h5: begin acc_nx_o[ir_i[2:0]] = !ir_i[3]; acc_we_o = 1'b1; end
      4'h6: begin acc_nx_o = {4'h0, ir_i[3:0]}; acc_we_o = 1'b1; end
      4'h8: begin
        acc_we_o = 1'b1;
        case (ir_i)
          OP_INB:   acc_nx_o = acc_i + 8'd1;
          OP_DEB:   acc_nx_o = acc_i - 8'd1;
          OP_INBCD: acc_nx_o = bcd_inc(acc_i);
          OP_DEBCD: acc_nx_o = bcd_dec(acc_i);
          OP_CPL:   acc_nx_o = ~acc_i;
          OP_CLA:   acc_nx_o = '0;
          default:  acc_we_o = 1'b0;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 11'h400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        ir_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              skip_i,
  input  logic              irq_i,
  output logic              exec_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic              exec_q, ie_q;
  logic [ADDR_W-1:0] pc_q, ret_q, pc_nx, tgt;

  assign tgt = ADDR_W'({ir_i[2:0], acc_i});

  always_comb begin
    pc_nx = pc_q + (skip_i ? ADDR_W'(2) : ADDR_W'(1));
    if (ir_i[7:4] == 4'hC)                 pc_nx = tgt;
    else if (ir_i == OP_RET || ir_i == OP_RTI) pc_nx = ret_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= 1'b0;
      ie_q   <= 1'b0;
      pc_q   <= '0;
      ret_q  <= '0;
    end else if (!exec_q) begin
      exec_q <= 1'b1;
    end else begin
      exec_q <= 1'b0;
      pc_q   <= pc_nx;
      if (ir_i[7:3] == 5'b11001) ret_q <= pc_q + ADDR_W'(1);
      if (ir_i == OP_EI || ir_i == OP_RTI) ie_q <= 1'b1;
      if (ir_i == OP_DI)                    ie_q <= 1'b0;
      if (irq_i && ie_q) begin  // interrupt overrides everything
        ret_q <= pc_nx;
        pc_q  <= IRQ_VEC;
        ie_q  <= 1'b0;
      end
    end
  end

  assign exec_o = exec_q;
  assign pc_o   = pc_q;

  AST_PHASE_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_q |=> !exec_q) else $error("phase"); // R2
  AST_PC_HOLD_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_q |=> $stable(pc_q)) else $error("pc hold"); // R2
  AST_IRQ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_q && irq_i && ie_q) |=> (!ie_q && pc_q == IRQ_VEC)) else $error("irq"); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_q && !(exec_q && (ir_i == OP_EI || ir_i == OP_RTI))) |=> !ie_q) else $error("mask"); // R11
endmodule

// File: rtl/ctl_core.sv
module ctl_core
  import ctl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 11'h400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic [7:0]        instr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DCTL_W-1:0] dctl_o
);
  logic [7:0]        ir_q;
  logic [DATA_W-1:0] acc_q, acc_nx, reg_rd;
  logic [DCTL_W-1:0] dctl_q;
  logic              exec, acc_we, skip;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ir_q <= '0;
    else if (!exec) ir_q <= instr_i;
  end

  ctl_regfile u_rf (
    .clk_i, .rst_ni,
    .we_i   (exec && ir_q[7:4] == 4'h1),
    .idx_i  (ir_q[REG_AW-1:0]),
    .wdata_i(acc_q),
    .rdata_o(reg_rd)
  );

  ctl_acc_unit u_acc (
    .ir_i(ir_q), .acc_i(acc_q), .reg_i(reg_rd),
    .acc_nx_o(acc_nx), .acc_we_o(acc_we), .skip_o(skip)
  );

  ctl_seq #(.ADDR_W(ADDR_W), .IRQ_VEC(IRQ_VEC)) u_seq (
    .clk_i, .rst_ni,
    .ir_i(ir_q), .acc_i(acc_q), .skip_i(skip), .irq_i,
    .exec_o(exec), .pc_o(addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      dctl_q <= '0;
    end else if (exec) begin
      if (acc_we) acc_q <= acc_nx;
      if (ir_q == OP_DOUT)                      dctl_q <= acc_q[DCTL_W-1:0];
      else if (ir_q[7:4] == 4'h7 && ir_q[2:0] != 3'd7) dctl_q[ir_q[2:0]] <= !ir_q[3];
    end
  end

  assign acc_o  = acc_q;
  assign dctl_o = dctl_q;

  AST_DCTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> $stable(dctl_q)) else $error("dctl"); // R9
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> $stable(acc_q)) else $error("acc"); // R2
  AST_BCD_DIGITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && (ir_q == OP_INBCD || ir_q == OP_DEBCD) && acc_q[3:0] <= 4'd9 && acc_q[7:4] <= 4'd9)
    |=> (acc_q[3:0] <= 4'd9 && acc_q[7:4] <= 4'd9)) else $error("bcd"); // R8
endmodule

// File: tb/ctl_core_tb.sv
module ctl_core_tb_top;
  localparam int VEC = 'h400;
  logic clk_i = 1'b0, rst_ni = 1'b0, irq_i = 1'b0;
  logic [7:0]  instr_i;
  logic [10:0] addr_o;
  logic [7:0]  acc_o;
  logic [6:0]  dctl_o;
  logic [7:0]  mem [2048];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ctl_core dut_i (.clk_i, .rst_ni, .irq_i, .instr_i, .addr_o, .acc_o, .dctl_o);

  always #10 clk_i = ~clk_i;
  assign instr_i = mem[addr_o];

  // reference model
  int mpc, macc, mdctl, mret, mie, mexec, mir, last_op;
  int mreg [16];

  function automatic string tag(input int op);
    if (op < 'h10 || (op >= 'h10 && op < 'h20) || (op >= 'h60 && op < 'h70)) return "R3";
    if (op < 'h40) return "R6";
    if (op < 'h50) return "R5";
    if (op < 'h60) return "R4";
    if (op < 'h80) return "R9";
    if (op == 'h80 || op == 'h81 || op == 'h84 || op == 'h85) return "R7";
    if (op == 'h82 || op == 'h83) return "R8";
    if (op == 'h86 || (op >= 'hC0 && op < 'hD0)) return "R10";
    if (op >= 'h87 && op <= 'h89) return "R11";
    return "R12";
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpc = 0; macc = 0; mdctl = 0; mret = 0; mie = 0; mexec = 0; mir = 0; last_op = -1;
      foreach (mreg[i]) mreg[i] = 0;
    end else if (!mexec) begin
      mir = mem[mpc]; mexec = 1;
    end else begin
      int op, nxt, b, d, ie_old;
      bit skip;
      op = mir; b = op & 7; skip = 0; ie_old = mie;
      nxt = (mpc + 1) % 2048;
      if (op < 'h10) macc = mreg[op & 15];
      else if (op < 'h20) mreg[op & 15] = macc;
      else if (op < 'h30) skip = (macc == mreg[op & 15]);
      else if (op < 'h40) skip = (macc > mreg[op & 15]);
      else if (op < 'h48) skip = ((macc >> b) & 1) == 1;
      else if (op < 'h50) skip = ((macc >> b) & 1) == 0;
      else if (op < 'h58) macc = macc | (1 << b);
      else if (op < 'h60) macc = macc & ~(1 << b) & 255;
      else if (op < 'h70) macc = op & 15;
      else if (op < 'h80) begin
        if (op == 'h77) mdctl = macc & 127;
        else if (b != 7) mdctl = (op < 'h78) ? (mdctl | (1 << b)) : (mdctl & ~(1 << b) & 127);
      end else if (op == 'h80) macc = (macc + 1) % 256;
      else if (op == 'h81) macc = (macc + 255) % 256;
      else if (op == 'h82 || op == 'h83) begin
        d = (macc >> 4) * 10 + (macc & 15);
        d = (op == 'h82) ? (d + 1) % 100 : (d + 99) % 100;
        macc = (d / 10) * 16 + d % 10;
      end else if (op == 'h84) macc = macc ^ 255;
      else if (op == 'h85) macc = 0;
      else if (op == 'h86) nxt = mret;
      else if (op == 'h87) begin nxt = mret; mie = 1; end
      else if (op == 'h88) mie = 1;
      else if (op == 'h89) mie = 0;
      else if (op >= 'hC0 && op < 'hD0) begin
        if (op >= 'hC8) mret = (mpc + 1) % 2048;
        nxt = (b << 8) | macc;
      end
      if (skip) nxt = (mpc + 2) % 2048;
      if (irq_i && ie_old != 0) begin mret = nxt; nxt = VEC; mie = 0; end
      mpc = nxt; mexec = 0; last_op = op;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done && last_op >= 0) begin
      chk({"R2 ", tag(last_op)}, "addr", int'(addr_o), mpc);
      chk(tag(last_op), "acc", int'(acc_o), macc);
      chk(tag(last_op), "dctl", int'(dctl_o), mdctl);
    end
  end

  task automatic put(input int a, input int v); mem[a] = 8'(v); endtask

  initial begin
    foreach (mem[i]) mem[i] = 8'hFF;
    // main program
    put('h00,'h69); put('h01,'h82); put('h02,'h11); put('h03,'h60);
    put('h04,'h81); put('h05,'h80); put('h06,'h83); put('h07,'h82);
    put('h08,'h57); put('h09,'h47); put('h0A,'h65); put('h0B,'h4F);
    put('h0C,'h5F); put('h0D,'h84); put('h0E,'h77); put('h0F,'h78);
    put('h10,'h01); put('h11,'h21); put('h12,'h61); put('h13,'h31);
    put('h14,'h63); put('h15,'h62); put('h16,'hC9); put('h17,'h88);
    put('h18,'h6F); put('h19,'h12); put('h1A,'h01); put('h1B,'h32);
    put('h1C,'h60); put('h1D,'h40); put('h1E,'h48); put('h1F,'h60);
    put('h20,'h7E); put('h21,'h76); put('h22,'h85); put('h23,'h7F);
    put('h102,'h50); put('h103,'h86);
    put('h400,'h67); put('h401,'h7E); put('h402,'h52); put('h403,'h87);

    // R1: reset state
    #15;
    n_chk++; if (addr_o !== 0 || acc_o !== 0 || dctl_o !== 0) begin
      n_fail++; $display("FAIL R1 reset actual=%0h/%0h/%0h expected=0/0/0", addr_o, acc_o, dctl_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    // R11: irq while disabled is ignored
    repeat (6) @(negedge clk_i);
    irq_i = 1'b1;
    repeat (4) @(negedge clk_i);
    irq_i = 1'b0;
    repeat (80) @(negedge clk_i);
    // R11: irq after enable enters vector
    irq_i = 1'b1;
    repeat (3) @(negedge clk_i);
    irq_i = 1'b0;
    repeat (30) @(negedge clk_i);
    irq_i = 1'b1;
    repeat (2) @(negedge clk_i);
    irq_i = 1'b0;
    repeat (30) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule